// File: doc/BRIEF.md
# MSI Pending Vector Scanner

This engine services one group of a message-signalled interrupt termination bank. A group is made of a summary register and a set of index registers. Each summary bit marks an index register that holds pending vectors. Each index register holds one pending flag per vector, and reading it clears it in hardware. When the group's interrupt line is high, the scanner reads the summary. It then walks the set summary bits from the lowest upward. For each one it reads that index register exactly once and hands out every pending vector number, lowest bit first, on a valid/ready stream.

The scanner keeps private copies of the summary and of the index register under service, and clears bits from them as it goes. When the summary copy is empty, it reads the summary again. If new work has arrived, it keeps scanning; if the re-read returns zero, it goes back to idle. Register reads use a request/response port. A request is held until it is accepted, a response may come back after any latency, and only one read is ever in flight. The vector stream follows valid/ready rules: once valid is high, it and the vector number stay unchanged until ready is seen high at a clock edge. A transfer happens on every edge where both are high, and while ready is low the scan simply pauses.

Top module: `msi_vec_scanner`

## Requirements
- R1: After reset, and in idle while grp_irq_i is low, the scanner issues no read request and presents no vector.
- R2: When grp_irq_i is high in idle, the first read issued is a summary read (rd_req_sum_o = 1).
- R3: The summary copy is walked lowest set index first, and within an index register the lowest set bit is emitted first.
- R4: Every index the scanner selects is read exactly once for that selection, as an index read (rd_req_sum_o = 0) with rd_req_idx_o equal to the index.
- R5: Each emitted number equals ((index * 16) + bit) * 16 + group, where group is grp_id_i and bit is the position in the index read data.
- R6: Every set bit returned by an index read is emitted exactly once, and no other vector is emitted.
- R7: While vec_valid_o is high and vec_ready_i is low, vec_valid_o stays high and vec_num_o stays unchanged.
- R8: While rd_req_valid_o is high and rd_req_ready_i is low, the request stays valid and its kind and index stay unchanged.
- R9: Once the summary copy is empty, the summary is read again, and any index pending on that re-read is scanned the same way.
- R10: A summary read that returns zero sends the scanner to idle; an index read that returns zero emits nothing and the scan moves on to the next index.
- R11: At most one read is outstanding, and no new request is raised until the previous response (rd_rsp_valid_i) has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_irq_i | input | 1 | Group interrupt line, level |
| grp_id_i | input | 4 | Number of the serviced group, held static |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_sum_o | output | 1 | 1: summary read, 0: index read |
| rd_req_idx_o | output | 3 | Index register number for an index read |
| rd_rsp_valid_i | input | 1 | Read response valid, one cycle per request |
| rd_rsp_data_i | input | 16 | Read data; for a summary read, bit i marks index i |
| vec_valid_o | output | 1 | Vector valid |
| vec_ready_i | input | 1 | Vector accepted |
| vec_num_o | output | 11 | Pending vector number |

## Verification
The assertions assume that the responder returns exactly one response per accepted request, and only after the request is accepted. They also assume that grp_id_i does not change while a scan is running. The bench model answers each accepted read once, after a programmable latency, and changes the group number only between runs, once the block is quiet. It clears index contents only when they are read, and it adds new pending bits either between runs or at a chosen vector handshake. A spurious summary bit is driven only on the first summary read of a run.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUM_REQ,
    ST_SUM_WAIT,
    ST_IDX_REQ,
    ST_IDX_WAIT,
    ST_EMIT
  } scan_st_e;

endpackage

// File: rtl/msi_lsb_pick.sv
module msi_lsb_pick #(
  parameter int W = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [PW-1:0] pos_o
);

  always_comb begin
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
  end

  assign any_o = |vec_i;

  logic [W-1:0] below_mask;
  assign below_mask = (W'(1) << pos_o) - W'(1);

  always_comb begin
    if (any_o) begin
      AST_LSB_LOWEST: assert (vec_i[pos_o] && ((vec_i & below_mask) == '0)); // R3
    end
  end

endmodule

// File: rtl/msi_vec_compose.sv
module msi_vec_compose #(
  parameter int NUM_IDX = 8,
  parameter int BITS    = 16,
  parameter int NGROUPS = 16,
  localparam int IW = $clog2(NUM_IDX),
  localparam int BW = $clog2(BITS),
  localparam int GW = $clog2(NGROUPS),
  localparam int VW = $clog2(NUM_IDX * BITS * NGROUPS)
) (
  input  logic [IW-1:0] idx_i,
  input  logic [BW-1:0] bit_i,
  input  logic [GW-1:0] grp_i,
  output logic [VW-1:0] num_o
);

  logic [31:0] wide;

  always_comb begin
    wide  = ((32'(idx_i) * 32'(BITS)) + 32'(bit_i)) * 32'(NGROUPS) + 32'(grp_i);
    num_o = wide[VW-1:0];
  end

endmodule

// File: rtl/msi_scan_fsm.sv
module msi_scan_fsm
  import msi_scan_pkg::*;
#(
  parameter int NUM_IDX = 8,
  parameter int BITS    = 16,
  localparam int IW = $clog2(NUM_IDX),
  localparam int BW = $clog2(BITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            grp_irq_i,
  output logic            rd_req_valid_o,
  input  logic            rd_req_ready_i,
  output logic            rd_req_sum_o,
  output logic [IW-1:0]   rd_req_idx_o,
  input  logic            rd_rsp_valid_i,
  input  logic [BITS-1:0] rd_rsp_data_i,
  output logic            vec_valid_o,
  input  logic            vec_ready_i,
  output logic [IW-1:0]   vec_idx_o,
  output logic [BW-1:0]   vec_bit_o
);

  scan_st_e          state_q;
  logic [NUM_IDX-1:0] sum_q;
  logic [BITS-1:0]    bits_q;
  logic [IW-1:0]      idx_q;

  logic [NUM_IDX-1:0] sum_clr, sum_src;
  logic [BITS-1:0]    bits_clr, bit_src;
  logic               sum_any, bit_any;
  logic [IW-1:0]      sum_pos;
  logic [BW-1:0]      bit_pos;

  assign sum_clr  = sum_q & ~(NUM_IDX'(1) << idx_q);
  assign sum_src  = (state_q == ST_SUM_WAIT) ? rd_rsp_data_i[NUM_IDX-1:0] : sum_clr;
  assign bit_src  = (state_q == ST_IDX_WAIT) ? rd_rsp_data_i : bits_q;
  assign bits_clr = bits_q & ~(BITS'(1) << bit_pos);

  msi_lsb_pick #(.W(NUM_IDX)) u_sum_pick (
    .vec_i (sum_src),
    .any_o (sum_any),
    .pos_o (sum_pos)
  );

  msi_lsb_pick #(.W(BITS)) u_bit_pick (
    .vec_i (bit_src),
    .any_o (bit_any),
    .pos_o (bit_pos)
  );

  assign rd_req_valid_o = (state_q == ST_SUM_REQ) || (state_q == ST_IDX_REQ);
  assign rd_req_sum_o   = (state_q == ST_SUM_REQ);
  assign rd_req_idx_o   = idx_q;
  assign vec_valid_o    = (state_q == ST_EMIT);
  assign vec_idx_o      = idx_q;
  assign vec_bit_o      = bit_pos;

  logic unused_any;
  assign unused_any = bit_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sum_q   <= '0;
      bits_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (grp_irq_i) state_q <= ST_SUM_REQ;
        end
        ST_SUM_REQ: begin
          if (rd_req_ready_i) state_q <= ST_SUM_WAIT;
        end
        ST_SUM_WAIT: begin
          if (rd_rsp_valid_i) begin
            sum_q <= rd_rsp_data_i[NUM_IDX-1:0];
            if (sum_any) begin
              idx_q   <= sum_pos;
              state_q <= ST_IDX_REQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_IDX_REQ: begin
          if (rd_req_ready_i) state_q <= ST_IDX_WAIT;
        end
        ST_IDX_WAIT: begin
          if (rd_rsp_valid_i) begin
            bits_q <= rd_rsp_data_i;
            if (rd_rsp_data_i != '0) begin
              state_q <= ST_EMIT;
            end else begin
              sum_q <= sum_clr;
              if (sum_any) begin
                idx_q   <= sum_pos;
                state_q <= ST_IDX_REQ;
              end else begin
                state_q <= ST_SUM_REQ;
              end
            end
          end
        end
        ST_EMIT: begin
          if (vec_ready_i) begin
            bits_q <= bits_clr;
            if (bits_clr == '0) begin
              sum_q <= sum_clr;
              if (sum_any) begin
                idx_q   <= sum_pos;
                state_q <= ST_IDX_REQ;
              end else begin
                state_q <= ST_SUM_REQ;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (rd_req_valid_o && rd_req_ready_i) pend_q <= 1'b1;
    else if (rd_rsp_valid_i) pend_q <= 1'b0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!rd_req_valid_o && !vec_valid_o)); // R1

  AST_START_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && grp_irq_i) |=> (rd_req_valid_o && rd_req_sum_o)); // R2

  AST_ONE_INFLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !rd_req_valid_o); // R11

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_valid_o && !rd_req_ready_i) |=>
      (rd_req_valid_o && $stable(rd_req_sum_o) && $stable(rd_req_idx_o))); // R8

  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ready_i) |=>
      (vec_valid_o && $stable(vec_idx_o) && $stable(vec_bit_o))); // R7

  AST_EMIT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> bits_q[bit_pos]); // R6

endmodule

// File: rtl/msi_vec_scanner.sv
module msi_vec_scanner #(
  parameter int NUM_IDX      = 8,
  parameter int BITS_PER_IDX = 16,
  parameter int NUM_GROUPS   = 16,
  localparam int IW = $clog2(NUM_IDX),
  localparam int BW = $clog2(BITS_PER_IDX),
  localparam int GW = $clog2(NUM_GROUPS),
  localparam int VW = $clog2(NUM_IDX * BITS_PER_IDX * NUM_GROUPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    grp_irq_i,
  input  logic [GW-1:0]           grp_id_i,
  output logic                    rd_req_valid_o,
  input  logic                    rd_req_ready_i,
  output logic                    rd_req_sum_o,
  output logic [IW-1:0]           rd_req_idx_o,
  input  logic                    rd_rsp_valid_i,
  input  logic [BITS_PER_IDX-1:0] rd_rsp_data_i,
  output logic                    vec_valid_o,
  input  logic                    vec_ready_i,
  output logic [VW-1:0]           vec_num_o
);

  logic [IW-1:0] vec_idx;
  logic [BW-1:0] vec_bit;

  msi_scan_fsm #(
    .NUM_IDX (NUM_IDX),
    .BITS    (BITS_PER_IDX)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .grp_irq_i      (grp_irq_i),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_sum_o   (rd_req_sum_o),
    .rd_req_idx_o   (rd_req_idx_o),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .rd_rsp_data_i  (rd_rsp_data_i),
    .vec_valid_o    (vec_valid_o),
    .vec_ready_i    (vec_ready_i),
    .vec_idx_o      (vec_idx),
    .vec_bit_o      (vec_bit)
  );

  msi_vec_compose #(
    .NUM_IDX (NUM_IDX),
    .BITS    (BITS_PER_IDX),
    .NGROUPS (NUM_GROUPS)
  ) u_compose (
    .idx_i (vec_idx),
    .bit_i (vec_bit),
    .grp_i (grp_id_i),
    .num_o (vec_num_o)
  );

  AST_NUM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ready_i) |=> $stable(vec_num_o)); // R7

endmodule

// File: tb/msi_vec_scanner_tb_top.sv
module msi_vec_scanner_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq;
  logic [3:0]  grp_id = '0;
  logic        rd_req_valid, rd_req_ready, rd_req_sum;
  logic [2:0]  rd_req_idx;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        vec_valid, vec_ready;
  logic [10:0] vec_num;

  always #10 clk = ~clk;

  msi_vec_scanner dut_i (
    .clk_i (clk), .rst_ni (rst_n), .grp_irq_i (irq), .grp_id_i (grp_id),
    .rd_req_valid_o (rd_req_valid), .rd_req_ready_i (rd_req_ready),
    .rd_req_sum_o (rd_req_sum), .rd_req_idx_o (rd_req_idx),
    .rd_rsp_valid_i (rsp_valid), .rd_rsp_data_i (rsp_data),
    .vec_valid_o (vec_valid), .vec_ready_i (vec_ready), .vec_num_o (vec_num)
  );

  // stimulus controls, driven only by the initial block
  logic         clr_go = 0, inj_go = 0, arm_mid = 0;
  logic [127:0] inj_pat = '0, mid_pat = '0;
  logic [7:0]   inj_ghost = '0;
  int           lat = 0, mid_at = 0;
  logic [1:0]   rdy_mode = '0;

  // model state, driven only by the model block
  logic [15:0] mreg [8];
  logic [7:0]  ghost;
  logic        busy, q_sum, first_seen, first_sum;
  logic [2:0]  q_idx;
  int          lat_cnt, sum_reads, idx_reads, ncap, stall_err, req_err, ovl_err;
  logic [10:0] cap [64];
  logic        stall_q, rq_stall_q, rq_sum_q;
  logic [10:0] stall_num;
  logic [2:0]  rq_idx_q;
  int          cyc;

  always_comb begin
    irq = |ghost;
    for (int i = 0; i < 8; i++) irq = irq | (|mreg[i]);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_req_ready <= rdy_mode[0] ? cyc[0] : 1'b1;
    vec_ready    <= rdy_mode[1] ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    logic [15:0] t [8];
    logic [7:0]  g, nz;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mreg[i] <= '0;
      ghost <= '0; busy <= 0; q_sum <= 0; q_idx <= '0; lat_cnt <= 0;
      rsp_valid <= 0; rsp_data <= '0; sum_reads <= 0; idx_reads <= 0;
      ncap <= 0; stall_err <= 0; req_err <= 0; ovl_err <= 0;
      stall_q <= 0; stall_num <= '0; rq_stall_q <= 0; rq_sum_q <= 0; rq_idx_q <= '0;
      first_seen <= 0; first_sum <= 0;
    end else begin
      for (int i = 0; i < 8; i++) t[i] = mreg[i];
      g = ghost;
      rsp_valid <= 1'b0;
      if (busy) begin
        if (lat_cnt == 0) begin
          busy <= 1'b0;
          rsp_valid <= 1'b1;
          if (q_sum) begin
            nz = '0;
            for (int i = 0; i < 8; i++) nz[i] = |t[i];
            rsp_data <= {8'h00, nz | g};
            g = '0;
            sum_reads <= sum_reads + 1;
          end else begin
            rsp_data <= t[q_idx];
            t[q_idx] = '0;
            idx_reads <= idx_reads + 1;
          end
        end else begin
          lat_cnt <= lat_cnt - 1;
        end
      end
      if (rd_req_valid && rd_req_ready) begin
        if (busy) ovl_err <= ovl_err + 1;
        busy <= 1'b1; lat_cnt <= lat; q_sum <= rd_req_sum; q_idx <= rd_req_idx;
        if (!first_seen) begin first_seen <= 1'b1; first_sum <= rd_req_sum; end
      end
      if (rd_req_valid && busy) ovl_err <= ovl_err + 1;
      if (rq_stall_q && (!rd_req_valid || rd_req_sum != rq_sum_q || rd_req_idx != rq_idx_q))
        req_err <= req_err + 1;
      rq_stall_q <= rd_req_valid && !rd_req_ready;
      rq_sum_q <= rd_req_sum; rq_idx_q <= rd_req_idx;
      if (stall_q && (!vec_valid || vec_num != stall_num)) stall_err <= stall_err + 1;
      stall_q <= vec_valid && !vec_ready;
      stall_num <= vec_num;
      if (vec_valid && vec_ready) begin
        if (ncap < 64) cap[ncap] <= vec_num;
        if (arm_mid && ncap == mid_at)
          for (int i = 0; i < 8; i++) t[i] = t[i] | mid_pat[i*16 +: 16];
        ncap <= ncap + 1;
      end
      if (inj_go) begin
        for (int i = 0; i < 8; i++) t[i] = t[i] | inj_pat[i*16 +: 16];
        g = g | inj_ghost;
      end
      if (clr_go) begin
        sum_reads <= 0; idx_reads <= 0; ncap <= 0; stall_err <= 0;
        req_err <= 0; ovl_err <= 0; first_seen <= 0;
      end
      for (int i = 0; i < 8; i++) mreg[i] <= t[i];
      ghost <= g;
    end
  end

  int errors = 0, checks = 0;
  int expv [64];
  int nexp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_exp(input logic [127:0] p, input int gid);
    for (int i = 0; i < 8; i++)
      for (int b = 0; b < 16; b++)
        if (p[i*16 + b] && nexp < 64) begin
          expv[nexp] = ((i * 16) + b) * 16 + gid;
          nexp++;
        end
  endtask

  function automatic int nz_count(input logic [127:0] p);
    int n = 0;
    for (int i = 0; i < 8; i++) if (p[i*16 +: 16] != '0) n++;
    return n;
  endfunction

  task automatic wait_quiet();
    int q = 0;
    int guard = 0;
    while (q < 30 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!rd_req_valid && !vec_valid && !busy && !rsp_valid && !irq) q++; else q = 0;
    end
    chk(guard < 20000, "R10", "scan returned to idle", guard, 0);
  endtask

  task automatic run_case(input logic [127:0] p, input logic [7:0] gh, input int gid,
                          input int l, input logic [1:0] mode, input bit arm,
                          input int at, input logic [127:0] mp,
                          input int exp_sum, input int exp_idx, input string tag);
    @(negedge clk);
    grp_id = 4'(gid); lat = l; rdy_mode = mode; arm_mid = arm; mid_at = at; mid_pat = mp;
    clr_go = 1;
    @(negedge clk);
    clr_go = 0; inj_pat = p; inj_ghost = gh; inj_go = 1;
    @(negedge clk);
    inj_go = 0;
    wait_quiet();
    nexp = 0;
    add_exp(p, gid);
    if (arm) add_exp(mp, gid);
    chk(first_seen && first_sum, "R2", {tag, " first read is summary"}, int'(first_sum), 1);
    chk(ncap == nexp, "R6", {tag, " vector count"}, ncap, nexp);
    for (int k = 0; k < nexp && k < ncap; k++)
      chk(int'(cap[k]) == expv[k], "R5", {tag, " vector number in R3 order"}, int'(cap[k]), expv[k]);
    chk(idx_reads == exp_idx, "R4", {tag, " index reads"}, idx_reads, exp_idx);
    chk(sum_reads == exp_sum, "R9", {tag, " summary reads"}, sum_reads, exp_sum);
    chk(stall_err == 0, "R7", {tag, " vector held under stall"}, stall_err, 0);
    chk(req_err == 0, "R8", {tag, " request held under stall"}, req_err, 0);
    chk(ovl_err == 0, "R11", {tag, " single read in flight"}, ovl_err, 0);
  endtask

  localparam logic [127:0] PAT [4] = '{
    128'h0000_0000_0000_0000_0000_0000_0000_0001,
    128'h0000_0000_0410_0000_0000_8001_0000_0000,
    128'hFFFF_0000_0000_0000_0000_0000_0000_0003,
    128'h0101_0101_0101_0101_0101_0101_0101_0101
  };
  localparam int         GRP  [4] = '{0, 7, 9, 15};
  localparam int         LATV [4] = '{0, 3, 1, 5};
  localparam logic [1:0] MODE [4] = '{2'd0, 2'd3, 2'd2, 2'd1};

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_valid && !vec_valid, "R1", "outputs quiet in reset", int'(rd_req_valid | vec_valid), 0);
    rst_n = 1;
    begin
      int seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (rd_req_valid || vec_valid) seen++;
      end
      chk(seen == 0, "R1", "idle with interrupt low", seen, 0);
    end

    for (int e = 0; e < 4; e++)
      run_case(PAT[e], 8'h00, GRP[e], LATV[e], MODE[e], 1'b0, 0, '0,
               2, nz_count(PAT[e]), $sformatf("table%0d", e));

    // new work appears after the first vector; found by the summary re-read
    run_case(128'h0000_0000_0000_0000_0001_0000_0000_0006, 8'h00, 3, 2, 2'd2,
             1'b1, 0, 128'h0000_0000_0000_0000_0000_0000_0000_0001,
             3, 3, "R9 reread");

    // spurious summary bit: index read returns zero (R10)
    run_case(128'h0000_0000_0000_0000_0000_0000_0008_0000, 8'h04, 5, 1, 2'd1,
             1'b0, 0, '0, 2, 2, "R10 empty index");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule